// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address for every beat of an SDRAM read or write burst. A start strobe captures a 9-bit starting column, a 3-bit burst-length code and an ordering bit. The block then streams one column per beat on a valid/ready output. A fixed burst of 2, 4 or 8 beats stays inside the aligned block of that size, and ordering is either linear with wrap-around or by XOR of the beat index. A full-page burst runs linearly through the 512-column row, wraps from 511 to 0, and stops only when the terminate input ends it.

The output follows valid/ready rules. A beat is consumed on a rising edge where `beat_valid` and `beat_ready` are both high. While `beat_valid` is high and `beat_ready` is low, the column and the last flag hold steady and the burst does not advance. `start`, `term` and `mode_err` are plain control pins and are not handshaked. `start` takes priority over `term` and over any burst in progress.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `mode_err` are low.
- R2: In the cycle after `start` is sampled high, `beat_valid` is high and `beat_col` equals the captured starting column.
- R3: With `ilv`=0 and length code 001, 010 or 011 (2, 4 or 8 beats), beat k keeps the column bits above the block offset and puts (offset + k) mod length in the low 1, 2 or 3 bits.
- R4: With `ilv`=1 and a 2, 4 or 8 beat code, beat k puts offset XOR k in the low bits and keeps the upper bits.
- R5: Length code 000 gives one beat at the starting column with `beat_last` high, whatever `ilv` is.
- R6: Length code 111 (full page) gives beat k = (start + k) mod 512 for either value of `ilv`, never raises `beat_last`, and continues until terminated or restarted.
- R7: `beat_last` is high exactly on the final beat of a fixed burst. After that beat is consumed, `beat_valid` is low.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_col` and `beat_last` stay unchanged and no beat is skipped.
- R9: `term` sampled high while a burst is active and `start` is low ends the burst. `beat_valid` is low in the next cycle.
- R10: `start` sampled during an active burst, even with `term` high, restarts the burst at the new column from beat 0.
- R11: Length codes 100, 101 and 110 are reserved. They give a single beat at the starting column with `beat_last` high and set `mode_err`. `mode_err` holds until the next start with a defined code clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the parameters and begin a burst |
| start_col | input | 9 | Starting column |
| len_code | input | 3 | Burst length code: 000=1, 001=2, 010=4, 011=8, 111=full page |
| ilv | input | 1 | Ordering: 0 linear, 1 XOR (ignored for full page and length 1) |
| term | input | 1 | End the active burst after the current cycle |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat column is presented |
| beat_col | output | 9 | Column of the current beat |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Last start used a reserved length code |

## Verification
Two collisions can land in the same cycle. The first is a restart strobe together with a terminate request in the middle of a burst. The bench provokes it by raising `start` and `term` on the same edge two beats into an 8-beat burst, and judges it by requiring beat 0 of the new burst at the new column in the following cycle, then the full new sequence. The second is a stalled consumer on a beat where the block would otherwise advance. The bench holds `beat_ready` low for several cycles in the middle of a wrapping burst and requires the column to stay fixed and the sequence to resume with no gap.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_W = 9;
  localparam int OFF_W = 3;
  localparam int LOG_W = 2;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [LOG_W-1:0] len_log;
    logic             full;
    logic             err;
  } len_info_t;
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
  import burst_col_pkg::*;
(
  input  logic [2:0] code,
  output len_info_t  info
);
  always_comb begin
    info = '0;
    unique case (code)
      LEN_1:    info.len_log = 2'd0;
      LEN_2:    info.len_log = 2'd1;
      LEN_4:    info.len_log = 2'd2;
      LEN_8:    info.len_log = 2'd3;
      LEN_PAGE: info.full    = 1'b1;
      default:  info.err     = 1'b1;
    endcase
  end
endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int COL_W = 9,
  parameter int OFF_W = 3,
  parameter int LOG_W = 2
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [LOG_W-1:0] len_log,
  input  logic             ilv,
  input  logic             full,
  output logic [COL_W-1:0] col
);
  logic [OFF_W-1:0] lin_low;
  logic [OFF_W-1:0] xor_low;
  logic [OFF_W-1:0] mix_low;
  logic [COL_W-1:0] page_col;

  assign lin_low  = base[OFF_W-1:0] + beat[OFF_W-1:0];
  assign xor_low  = base[OFF_W-1:0] ^ beat[OFF_W-1:0];
  assign page_col = base + beat;

  for (genvar i = 0; i < OFF_W; i++) begin : g_bit
    logic in_block;
    assign in_block   = (LOG_W'(i) < len_log);
    assign mix_low[i] = in_block ? (ilv ? xor_low[i] : lin_low[i]) : base[i];
  end

  assign col = full ? page_col : {base[COL_W-1:OFF_W], mix_low};
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic             term,
  input  logic             beat_ready,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             mode_err
);
  len_info_t        dec;
  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [LOG_W-1:0] log_q;
  logic             full_q;
  logic             ilv_q;
  logic             err_q;
  logic [COL_W-1:0] final_beat;
  logic             fire;

  burst_len_dec u_dec (
    .code (len_code),
    .info (dec)
  );

  burst_order #(
    .COL_W (COL_W),
    .OFF_W (OFF_W),
    .LOG_W (LOG_W)
  ) u_order (
    .base    (base_q),
    .beat    (beat_q),
    .len_log (log_q),
    .ilv     (ilv_q),
    .full    (full_q),
    .col     (beat_col)
  );

  always_comb begin
    final_beat = '0;
    final_beat[OFF_W-1:0] = OFF_W'((4'd1 << log_q) - 4'd1);
  end

  assign beat_valid = active_q;
  assign beat_last  = active_q && !full_q && (beat_q == final_beat);
  assign mode_err   = err_q;
  assign fire       = active_q && beat_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      log_q    <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      err_q    <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col;
      log_q    <= dec.len_log;
      full_q   <= dec.full;
      ilv_q    <= ilv;
      err_q    <= dec.err;
    end else if (term) begin
      active_q <= 1'b0;
    end else if (fire) begin
      if (beat_last) active_q <= 1'b0;
      else           beat_q   <= beat_q + 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !beat_valid && !mode_err);

  p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> beat_valid && beat_col == $past(start_col));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && !start && !term
      |=> beat_valid && $stable(beat_col) && $stable(beat_last));

  p_term_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && term && !start |=> !beat_valid);

  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_last && beat_ready && !start |=> !beat_valid);

  p_err_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && mode_err |-> beat_last);
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       ilv = 1'b0;
  logic       term = 1'b0;
  logic       beat_ready = 1'b1;
  logic       beat_valid;
  logic [8:0] beat_col;
  logic       beat_last;
  logic       mode_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_col_gen u_dut (
    .clk, .rst_n, .start, .start_col, .len_code, .ilv, .term,
    .beat_ready, .beat_valid, .beat_col, .beat_last, .mode_err
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int code, input bit il, input int k);
    int len;
    int off;
    int low;
    case (code)
      1: len = 2;
      2: len = 4;
      3: len = 8;
      7: return (s + k) % 512;
      default: len = 1;
    endcase
    off = s % len;
    low = il ? (off ^ k) : ((off + k) % len);
    return s - off + low;
  endfunction

  function automatic int exp_len(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic kick(input int s, input int code, input bit il);
    @(negedge clk);
    start = 1'b1; start_col = 9'(s); len_code = 3'(code); ilv = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_fixed(input string req, input int s, input int code, input bit il);
    int len = exp_len(code);
    kick(s, code, il);
    beat_ready = 1'b1;
    for (int k = 0; k < len; k++) begin
      check({req, " valid"}, beat_valid, 1);
      check({req, " col"}, beat_col, exp_col(s, code, il, k));
      check({req, " last"}, beat_last, (k == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    check({req, " R7 idle after last"}, beat_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 valid", beat_valid, 0);
    check("R1 last", beat_last, 0);
    check("R1 err", mode_err, 0);
  endtask

  task automatic t_seq();
    run_fixed("R3 seq8 from 5", 5, 3, 1'b0);
    run_fixed("R3 seq4 from 0x1A6", 9'h1A6, 2, 1'b0);
    run_fixed("R3 seq2 from 0x0FF", 9'h0FF, 1, 1'b0);
  endtask

  task automatic t_ilv();
    run_fixed("R4 ilv8 from 0x15", 9'h15, 3, 1'b1);
    run_fixed("R4 ilv4 from 0x0B", 9'h0B, 2, 1'b1);
  endtask

  task automatic t_single();
    run_fixed("R5 len1 ilv", 9'h133, 0, 1'b1);
    check("R2 len1 err clear", mode_err, 0);
  endtask

  task automatic t_page();
    kick(508, 7, 1'b1);
    for (int k = 0; k < 10; k++) begin
      check("R6 page col", beat_col, exp_col(508, 7, 1'b0, k));
      check("R6 page no last", beat_last, 0);
      @(negedge clk);
    end
    check("R6 page still valid", beat_valid, 1);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    check("R9 term drop", beat_valid, 0);
  endtask

  task automatic t_stall();
    kick(6, 3, 1'b0);
    check("R2 stall first", beat_col, 6);
    @(negedge clk);
    beat_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 hold col", beat_col, 7);
      check("R8 hold valid", beat_valid, 1);
    end
    beat_ready = 1'b1;
    @(negedge clk);
    check("R8 resume", beat_col, 0);
  endtask

  task automatic t_restart();
    kick(0, 3, 1'b0);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; term = 1'b1; start_col = 9'd100; len_code = 3'd2; ilv = 1'b1;
    @(negedge clk);
    start = 1'b0; term = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R10 restart valid", beat_valid, 1);
      check("R10 restart col", beat_col, exp_col(100, 2, 1'b1, k));
      @(negedge clk);
    end
    check("R10 restart end", beat_valid, 0);
  endtask

  task automatic t_reserved();
    kick(77, 5, 1'b1);
    check("R11 col", beat_col, 77);
    check("R11 last", beat_last, 1);
    check("R11 err", mode_err, 1);
    @(negedge clk);
    check("R11 single beat", beat_valid, 0);
    check("R11 err held", mode_err, 1);
    kick(3, 1, 1'b0);
    check("R11 err cleared", mode_err, 0);
    check("R2 col after err", beat_col, 3);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_single();
    t_page();
    t_stall();
    t_restart();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule